// File: doc/BRIEF.md
# Synchronous Character Transmitter with Sync Fill

This block serialises characters for a character-oriented synchronous link at one bit per clock. Software or an upstream engine places a byte in a single holding register; the transmitter moves it into a shift register at the next character boundary. Characters follow each other with no gaps and no start or stop bits. Each character is 5 to 8 bits long and may carry a parity bit.

When a character boundary arrives and the holding register is empty, the transmitter keeps the line busy by sending a fill unit. The mode inputs pick the unit: one sync byte, a pair of sync bytes, or an escape byte followed by the first sync byte for transparent links. A fill unit is never split by data. A one-cycle flag marks each unit that starts because data was missing. The enable input parks the line at logic 1 and drops any unfinished unit.

Top module: `sync_fill_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, txd_o is 1, hold_empty_o is 1, and underrun_o and fill_active_o are 0.
- R2: While tx_en_i is 0, txd_o is 1 and underrun_o and fill_active_o are 0. A fill unit that was cut short is not resumed. After re-enabling, the first character starts on the next clock edge.
- R3: Every character is sent LSB first at one bit per clock. Its data length comes from char_len_i (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits). There are no start or stop bits, and characters follow back to back while tx_en_i is 1.
- R4: When par_en_i is 1, one parity bit follows the data bits. With par_odd_i = 1 the data bits and parity bit hold an odd number of ones; with par_odd_i = 0 they hold an even number. Fill characters get parity too.
- R5: With transparent_i = 0 and single_sync_i = 1, a fill unit is syn_a_i alone.
- R6: With transparent_i = 0 and single_sync_i = 0, a fill unit is syn_a_i followed by syn_b_i.
- R7: With transparent_i = 1, a fill unit is esc_i followed by syn_a_i, whatever single_sync_i is.
- R8: A fill unit starts only at a character boundary where the holding register is empty. Data loaded during a unit is sent right after the unit's last character.
- R9: underrun_o is high for exactly the first bit cycle of each fill unit and is low at all other times.
- R10: hold_empty_o goes low in the cycle after load_i. It goes high again in the cycle the held byte starts shifting. A load on that same edge keeps the holding register full with the new byte.
- R11: fill_active_o is 1 exactly while the bits of a fill character are on txd_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit enable; 0 parks the line at 1 |
| char_len_i | input | 2 | Data length code, 0..3 for 5..8 bits |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| single_sync_i | input | 1 | 1 = one sync byte per fill unit |
| transparent_i | input | 1 | 1 = escape-then-sync fill unit |
| syn_a_i | input | 8 | First sync byte |
| syn_b_i | input | 8 | Second sync byte |
| esc_i | input | 8 | Escape byte for transparent fill |
| load_i | input | 1 | Write load_data_i into the holding register |
| load_data_i | input | 8 | Byte to transmit |
| txd_o | output | 1 | Serial data out |
| hold_empty_o | output | 1 | Holding register is empty |
| underrun_o | output | 1 | One-cycle pulse at the start of each fill unit |
| fill_active_o | output | 1 | A fill character is on the line |

## Verification
The assertions assume that the format and fill inputs (length, parity, sync mode, fill bytes) only change while tx_en_i is low. Under that assumption every character and fill unit is built from one stable setting. The bench changes configuration only inside a disabled gap of a few cycles. Its random load pattern, including loads on consecutive cycles and enable drops at arbitrary bit positions, stays within this rule. Inputs are driven on the falling clock edge, so every rising edge sees settled values.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam int unsigned MIN_LEN = 5;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   nbits;
  } frame_t;

  // mask data to the programmed length, append parity above the data bits
  function automatic frame_t make_frame(logic [DATA_W-1:0] d, logic [1:0] len,
                                        logic par_en, logic par_odd);
    frame_t             f;
    logic [DATA_W-1:0]  m;
    logic               p;
    int unsigned        n;
    n = MIN_LEN + int'(len);
    m = d & (DATA_W'(8'hFF) >> (3 - len));
    p = (^m) ^ par_odd;
    f.bits  = {1'b0, m};
    f.nbits = CNT_W'(n);
    if (par_en) begin
      f.bits  = f.bits | (FRAME_W'(p) << n);
      f.nbits = CNT_W'(n + 1);
    end
    return f;
  endfunction
endpackage

// File: rtl/sft_hold_reg.sv
module sft_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (load_i) begin
      data_o <= data_i;
      full_o <= 1'b1;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sft_fill_seq.sv
module sft_fill_seq #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic         hold_full_i,
  input  logic [W-1:0] hold_data_i,
  input  logic         single_sync_i,
  input  logic         transparent_i,
  input  logic [W-1:0] syn_a_i,
  input  logic [W-1:0] syn_b_i,
  input  logic [W-1:0] esc_i,
  output logic [W-1:0] char_o,
  output logic         take_o,
  output logic         fill_o,
  output logic         unit_start_o
);
  logic         pend_q;
  logic [W-1:0] second_q;
  logic         pair;

  assign pair = transparent_i | ~single_sync_i;

  always_comb begin
    take_o       = 1'b0;
    unit_start_o = 1'b0;
    fill_o       = 1'b1;
    if (pend_q) begin
      char_o = second_q;
    end else if (hold_full_i) begin
      char_o = hold_data_i;
      take_o = step_i;
      fill_o = 1'b0;
    end else begin
      char_o       = transparent_i ? esc_i : syn_a_i;
      unit_start_o = step_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      second_q <= '0;
    end else if (!en_i) begin
      pend_q <= 1'b0;
    end else if (step_i) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (!hold_full_i) begin
        pend_q   <= pair;
        second_q <= transparent_i ? syn_a_i : syn_b_i;
      end
    end
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
  import sft_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   load_i,
  input  frame_t frame_i,
  input  logic   fill_i,
  input  logic   unit_start_i,
  output logic   boundary_o,
  output logic   txd_o,
  output logic   fill_o,
  output logic   underrun_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, fill_q, und_q;

  assign boundary_o = ~busy_q | (cnt_q == '0);
  assign txd_o      = (en_i & busy_q) ? sr_q[0] : 1'b1;
  assign fill_o     = en_i & busy_q & fill_q;
  assign underrun_o = en_i & und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fill_q <= 1'b0;
      und_q  <= 1'b0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      fill_q <= 1'b0;
      und_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sr_q   <= frame_i.bits;
      cnt_q  <= frame_i.nbits - CNT_W'(1);
      busy_q <= 1'b1;
      fill_q <= fill_i;
      und_q  <= unit_start_i;
    end else begin
      sr_q   <= sr_q >> 1;
      cnt_q  <= cnt_q - CNT_W'(1);
      und_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_fill_tx.sv
module sync_fill_tx
  import sft_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              single_sync_i,
  input  logic              transparent_i,
  input  logic [DATA_W-1:0] syn_a_i,
  input  logic [DATA_W-1:0] syn_b_i,
  input  logic [DATA_W-1:0] esc_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              underrun_o,
  output logic              fill_active_o
);
  logic              hold_full, take, boundary, step, next_fill, unit_start;
  logic [DATA_W-1:0] hold_data, next_char;
  frame_t            frame;

  assign step         = tx_en_i & boundary;
  assign hold_empty_o = ~hold_full;
  assign frame        = make_frame(next_char, char_len_i, par_en_i, par_odd_i);

  sft_hold_reg #(.W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .load_i, .data_i(load_data_i), .take_i(take),
    .data_o(hold_data), .full_o(hold_full)
  );

  sft_fill_seq #(.W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .en_i(tx_en_i), .step_i(step),
    .hold_full_i(hold_full), .hold_data_i(hold_data),
    .single_sync_i, .transparent_i, .syn_a_i, .syn_b_i, .esc_i,
    .char_o(next_char), .take_o(take), .fill_o(next_fill),
    .unit_start_o(unit_start)
  );

  sft_shifter u_sft (
    .clk_i, .rst_ni, .en_i(tx_en_i), .load_i(step), .frame_i(frame),
    .fill_i(next_fill), .unit_start_i(unit_start), .boundary_o(boundary),
    .txd_o, .fill_o(fill_active_o), .underrun_o
  );
endmodule

// File: rtl/sft_chk.sv
module sft_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic load_i,
  input logic txd_o,
  input logic hold_empty_o,
  input logic underrun_o,
  input logic fill_active_o
);
  // R2
  line_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> txd_o);
  // R2
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> (!underrun_o && !fill_active_o));
  // R9
  underrun_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);
  // R8
  underrun_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> $past(hold_empty_o));
  // R10
  load_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !hold_empty_o);
  // R11
  underrun_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> fill_active_o);
endmodule

bind sync_fill_tx sft_chk u_chk (.*);

// File: tb/sync_fill_tx_tb.sv
module sync_fill_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic       single_sync = 1'b1, transparent = 1'b0, load = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic [7:0] syn_a = 8'h16, syn_b = 8'h26, esc = 8'h10, ld_data = 8'h00;
  logic       txd, hold_empty, underrun, fill_active;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag_ovr = "";

  sync_fill_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .char_len_i(char_len),
    .par_en_i(par_en), .par_odd_i(par_odd), .single_sync_i(single_sync),
    .transparent_i(transparent), .syn_a_i(syn_a), .syn_b_i(syn_b),
    .esc_i(esc), .load_i(load), .load_data_i(ld_data), .txd_o(txd),
    .hold_empty_o(hold_empty), .underrun_o(underrun),
    .fill_active_o(fill_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic       m_full, m_pend, m_busy, m_fill, m_und;
  logic [7:0] m_hold, m_second;
  logic [8:0] m_sr;
  int         m_cnt;

  function automatic void build(input logic [7:0] d, output logic [8:0] b,
                                output int n);
    logic ones;
    n = 5 + int'(char_len);
    b = '0;
    ones = 1'b0;
    for (int i = 0; i < n; i++) begin
      b[i] = d[i];
      ones ^= d[i];
    end
    if (par_en) begin
      b[n] = ones ^ par_odd;
      n++;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 0; m_pend = 0; m_busy = 0; m_fill = 0; m_und = 0;
      m_hold = 0; m_second = 0; m_sr = 0; m_cnt = 0;
    end else begin
      logic       take, f, u;
      logic [7:0] ch;
      int         n;
      take = 0;
      if (!tx_en) begin
        m_busy = 0; m_pend = 0; m_und = 0; m_fill = 0; m_cnt = 0;
      end else if (!m_busy || m_cnt == 0) begin
        if (m_pend) begin
          ch = m_second; f = 1; u = 0; m_pend = 0;
        end else if (m_full) begin
          ch = m_hold; f = 0; u = 0; take = 1;
        end else begin
          ch = transparent ? esc : syn_a; f = 1; u = 1;
          m_pend = transparent | !single_sync;
          m_second = transparent ? syn_a : syn_b;
        end
        build(ch, m_sr, n);
        m_cnt = n - 1; m_busy = 1; m_fill = f; m_und = u;
      end else begin
        m_sr = m_sr >> 1; m_cnt--; m_und = 0;
      end
      if (load) begin
        m_hold = ld_data; m_full = 1;
      end else if (take) m_full = 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic string txd_tag();
    if (tag_ovr != "") return tag_ovr;
    if (!tx_en) return "R2";
    if (m_fill) return transparent ? "R7" : (single_sync ? "R5" : "R6");
    return par_en ? "R4" : "R3";
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(txd_tag(), txd, (tx_en && m_busy) ? m_sr[0] : 1'b1);
      chk("R9", underrun, m_und & tx_en);
      chk("R10", hold_empty, !m_full);
      chk("R11", fill_active, m_fill & m_busy & tx_en);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] l, input logic pe, input logic po,
                     input logic ss, input logic tr);
    @(negedge clk); tx_en = 0; load = 0;
    cyc(2);
    char_len = l; par_en = pe; par_odd = po; single_sync = ss; transparent = tr;
    syn_a = 8'($urandom); syn_b = 8'($urandom); esc = 8'($urandom);
    cyc(1);
    tx_en = 1;
  endtask

  task automatic run_rand(input int n, input int load_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load = ($urandom % 100) < load_pct;
      ld_data = 8'($urandom);
      if (($urandom % 250) == 0) begin
        tx_en = 0; load = 0;
        cyc(1 + $urandom % 4);
        tx_en = 1;
      end
    end
    @(negedge clk); load = 0;
  endtask

  initial begin
    void'($urandom(32'h51C0_0D17));
    #(CLK_PERIOD*3);
    // R1 reset values
    chk("R1", txd, 1'b1);
    chk("R1", hold_empty, 1'b1);
    chk("R1", underrun, 1'b0);
    chk("R1", fill_active, 1'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #2;
    chk("R1", txd, 1'b1);
    chk("R1", hold_empty, 1'b1);

    // R8: load in the middle of a double-sync unit
    tag_ovr = "R8";
    cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(3);
    load = 1; ld_data = 8'hA5;
    @(negedge clk); load = 0;
    cyc(30);
    tag_ovr = "";

    // R10: back-to-back loads while data is shifting
    cfg(2'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    run_rand(200, 100);

    // R7: transparent overrides single-sync
    cfg(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_rand(200, 10);

    for (int k = 0; k < 16; k++) begin
      cfg(2'(k % 4), 1'($urandom), 1'($urandom), 1'($urandom),
          1'(($urandom % 3) == 0));
      run_rand(500, 5 + ($urandom % 40));
    end

    cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_rand(300, 0);
    @(negedge clk); tx_en = 0;
    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule